// File: doc/BRIEF.md
# Eight-Bit Host Bus Access Sequencer

This block runs one read or one write at a time on an external 8-bit parallel bus for an internal requester. The requester presents an address, write data and a direction, and pulses a start while the block reports idle. The block walks the external pins through the access and returns a one-cycle completion pulse, with the captured byte for reads. The external bus timing is set by a clock enable (`tick`) that marks each bus clock. All timing below is counted in ticks.

Two bus arrangements are supported. In the shared arrangement, address and data take turns on the same eight wires, and an address-latch strobe marks the address. In the separate arrangement, the address has its own pins and the data phase starts at once. The data phase can be widened in two-tick steps, with an optional one-tick trim. The strobe polarities are set one by one. An external ready line can hold the data phase, with a sampling latency of 1 to 3 ticks. A short idle gap separates back-to-back accesses. The bus clock output can run freely, run only during an access, or be held low.

The controller states are IDLE, ADDR (address and latch strobe), DATA (read or write strobe), REL (strobes released, completion pulse) and GAP (spacing). The transitions are: IDLE to ADDR on start in the shared arrangement; IDLE to DATA on start in the separate arrangement; ADDR to DATA on the next tick; DATA to REL on the last unstalled tick of the strobe; REL to GAP after one system clock; GAP to IDLE when the gap ticks have elapsed.

Top module: `hb8_seq`

## Requirements
- R1: After reset, `cmd_idle` is 1 and `cmd_done` is 0. The read, write and latch strobes sit at their inactive levels.
- R2: The active strobe lasts 2×(code+1)−trim ticks, where code is the 2-bit wait field (0..3) and trim is 0 or 1. Reads use `cfg_rd_ws`/`cfg_rd_trim`, writes use `cfg_wr_ws`/`cfg_wr_trim`. The other strobe stays inactive for the whole access.
- R3: With `cfg_sep_bus`=0, every access has exactly one tick of active latch strobe before the data phase, whatever the wait settings. During that tick `bus_ad_out` carries address bits [7:0] and `bus_ad_oe`=1. With `cfg_sep_bus`=1 there is no latch strobe, and `bus_addr` carries the full address while the data strobe is active.
- R4: During a write strobe, `bus_ad_out` equals the write byte and `bus_ad_oe`=1. During a read strobe, `bus_ad_oe`=0. `cmd_rdata` takes `bus_ad_in` as sampled on the last tick of the read strobe.
- R5: Each strobe is active at the level of its own polarity bit (`cfg_rd_high`, `cfg_wr_high`, `cfg_ale_high`; 1 = active high) and is at the opposite level otherwise.
- R6: With `cfg_rdy_en`=1, `bus_rdy` is at its stall level when it equals `cfg_rdy_inv` (low normally, high when inverted). A stall level sampled on one tick holds the data-phase tick d ticks later, where d = `cfg_rdy_dly` and code 0 acts as 1. Each held tick lengthens the strobe by one tick. With `cfg_rdy_en`=0, `bus_rdy` has no effect.
- R7: `cmd_done` is high for exactly one system clock per access. It rises after the data strobe has gone inactive, and no strobe is active in that cycle.
- R8: From completion to the return of `cmd_idle`, the block spends 1 tick when `cfg_gap`=1 and 2 ticks for any other code.
- R9: A start while `cmd_idle`=0 is ignored. It launches no access and produces no completion.
- R10: `bus_clk` is high exactly in cycles with `tick`=1. `cfg_clk_gate`=1 forces it low. `cfg_clk_gate_idle`=1 forces it low whenever `cmd_idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bus clock enable, one pulse per bus clock |
| cmd_start | input | 1 | Start request, taken only while idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Access address |
| cmd_wdata | input | DW | Write byte |
| cmd_idle | output | 1 | Ready for a new start |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_rdata | output | DW | Byte captured by the last read |
| cfg_sep_bus | input | 1 | 0 = shared address/data, 1 = separate address pins |
| cfg_rd_ws | input | 2 | Read wait code |
| cfg_wr_ws | input | 2 | Write wait code |
| cfg_rd_trim | input | 1 | Shorten read strobe by one tick |
| cfg_wr_trim | input | 1 | Shorten write strobe by one tick |
| cfg_rd_high | input | 1 | Read strobe active high |
| cfg_wr_high | input | 1 | Write strobe active high |
| cfg_ale_high | input | 1 | Latch strobe active high |
| cfg_rdy_en | input | 1 | Enable ready stall |
| cfg_rdy_inv | input | 1 | Ready stall level is high |
| cfg_rdy_dly | input | 2 | Ready sampling latency in ticks (0 acts as 1) |
| cfg_gap | input | 2 | Idle gap code (1 = one tick, else two) |
| cfg_clk_gate | input | 1 | Hold bus clock low |
| cfg_clk_gate_idle | input | 1 | Bus clock only during an access |
| bus_clk | output | 1 | Bus clock output |
| bus_ale | output | 1 | Address-latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ad_out | output | DW | Shared address/data output byte |
| bus_ad_oe | output | 1 | Output enable for `bus_ad_out` |
| bus_ad_in | input | DW | Byte read from the bus |
| bus_addr | output | AW | Separate address pins |
| bus_rdy | input | 1 | External ready |

## Verification
Two events can fall on the same tick: a ready stall taking effect and the strobe's final counted tick. The bench provokes this by placing a single stall-level pulse a fixed number of data ticks before the strobe's end and sweeping the latency code. A stall that lands on or before the last tick must add exactly one tick to the strobe width; a stall that lands after it must add nothing. The gap phase also overlaps a fresh start pulse, and the bench judges that case by the absence of any strobe or completion afterwards.

// File: rtl/hb8_pkg.sv
package hb8_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_DATA = 3'd2,
        S_REL  = 3'd3,
        S_GAP  = 3'd4
    } hb8_state_e;
endpackage

// File: rtl/hb8_width_calc.sv
// Last-tick index of a data strobe: width = 2*(code+1) - trim, index = width-1.
module hb8_width_calc #(
    parameter int WS_W = 2
) (
    input  logic [WS_W-1:0] ws,
    input  logic            trim,
    output logic [WS_W:0]   last
);
    assign last = {ws, 1'b1} - {{WS_W{1'b0}}, trim};
endmodule

// File: rtl/hb8_rdy_delay.sv
// Samples the ready stall level on each tick and presents it again after a
// selectable number of ticks.
module hb8_rdy_delay #(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             inv,
    input  logic             rdy_in,
    input  logic [DLY_W-1:0] dly,
    output logic             stall
);
    localparam int MAX_DLY = (1 << DLY_W) - 1;

    logic [MAX_DLY-1:0] hist;
    logic [DLY_W-1:0]   sel;
    logic               lvl;

    assign lvl = (rdy_in == inv);
    assign sel = (dly == '0) ? '0 : dly - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist <= '0;
        else if (tick)
            hist <= {hist[MAX_DLY-2:0], lvl};
    end

    assign stall = en & hist[sel];

    p_rdy_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !stall);
endmodule

// File: rtl/hb8_pins.sv
// Output stage: strobe levels, shared bus drive and gated bus clock.
module hb8_pins #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  hb8_pkg::hb8_state_e state,
    input  logic          wr_q,
    input  logic          sep_q,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] wdata_q,
    input  logic          tick,
    input  logic          rd_high,
    input  logic          wr_high,
    input  logic          ale_high,
    input  logic          clk_gate,
    input  logic          clk_gate_idle,
    output logic          bus_clk,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    output logic [AW-1:0] bus_addr
);
    import hb8_pkg::*;

    logic rd_act, wr_act, ale_act;

    always_comb begin
        rd_act     = 1'b0;
        wr_act     = 1'b0;
        ale_act    = 1'b0;
        bus_ad_out = '0;
        bus_ad_oe  = 1'b0;
        unique case (state)
            S_ADDR: begin
                ale_act    = 1'b1;
                bus_ad_out = addr_q[DW-1:0];
                bus_ad_oe  = 1'b1;
            end
            S_DATA: begin
                if (wr_q) begin
                    wr_act     = 1'b1;
                    bus_ad_out = wdata_q;
                    bus_ad_oe  = 1'b1;
                end else begin
                    rd_act = 1'b1;
                end
            end
            S_IDLE, S_REL, S_GAP: ;
            default: ;
        endcase
    end

    assign bus_rd   = rd_act  ? rd_high  : ~rd_high;
    assign bus_wr   = wr_act  ? wr_high  : ~wr_high;
    assign bus_ale  = ale_act ? ale_high : ~ale_high;
    assign bus_addr = (sep_q && state != S_IDLE) ? addr_q : '0;
    assign bus_clk  = tick & ~clk_gate & (~clk_gate_idle | (state != S_IDLE));
endmodule

// File: rtl/hb8_seq.sv
module hb8_seq #(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int WS_W  = 2,
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [DW-1:0]    cmd_wdata,
    output logic             cmd_idle,
    output logic             cmd_done,
    output logic [DW-1:0]    cmd_rdata,
    input  logic             cfg_sep_bus,
    input  logic [WS_W-1:0]  cfg_rd_ws,
    input  logic [WS_W-1:0]  cfg_wr_ws,
    input  logic             cfg_rd_trim,
    input  logic             cfg_wr_trim,
    input  logic             cfg_rd_high,
    input  logic             cfg_wr_high,
    input  logic             cfg_ale_high,
    input  logic             cfg_rdy_en,
    input  logic             cfg_rdy_inv,
    input  logic [DLY_W-1:0] cfg_rdy_dly,
    input  logic [1:0]       cfg_gap,
    input  logic             cfg_clk_gate,
    input  logic             cfg_clk_gate_idle,
    output logic             bus_clk,
    output logic             bus_ale,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [DW-1:0]    bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [DW-1:0]    bus_ad_in,
    output logic [AW-1:0]    bus_addr,
    input  logic             bus_rdy
);
    import hb8_pkg::*;

    localparam int CW = WS_W + 1;

    hb8_state_e    state, nxt;
    logic [CW-1:0] cnt, rd_last, wr_last, load_last;
    logic          gcnt, gap_last, stall;
    logic          wr_q, sep_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;

    hb8_width_calc #(.WS_W(WS_W)) u_rd_w (.ws(cfg_rd_ws), .trim(cfg_rd_trim), .last(rd_last));
    hb8_width_calc #(.WS_W(WS_W)) u_wr_w (.ws(cfg_wr_ws), .trim(cfg_wr_trim), .last(wr_last));

    hb8_rdy_delay #(.DLY_W(DLY_W)) u_rdy (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(cfg_rdy_en),
        .inv(cfg_rdy_inv), .rdy_in(bus_rdy), .dly(cfg_rdy_dly), .stall(stall)
    );

    assign load_last = cmd_write ? wr_last : rd_last;
    assign gap_last  = (cfg_gap == 2'd1) ? 1'b0 : 1'b1;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (cmd_start) nxt = cfg_sep_bus ? S_DATA : S_ADDR;
            S_ADDR: if (tick) nxt = S_DATA;
            S_DATA: if (tick && !stall && cnt == '0) nxt = S_REL;
            S_REL:  nxt = S_GAP;
            S_GAP:  if (tick && !gcnt) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register and per-access datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            gcnt    <= 1'b0;
            wr_q    <= 1'b0;
            sep_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: if (cmd_start) begin
                    wr_q    <= cmd_write;
                    sep_q   <= cfg_sep_bus;
                    addr_q  <= cmd_addr;
                    wdata_q <= cmd_wdata;
                    cnt     <= load_last;
                end
                S_DATA: if (tick && !stall) begin
                    if (cnt == '0) begin
                        if (!wr_q) rdata_q <= bus_ad_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_REL:  gcnt <= gap_last;
                S_GAP:  if (tick && gcnt) gcnt <= 1'b0;
                S_ADDR: ;
                default: ;
            endcase
        end
    end

    assign cmd_idle  = (state == S_IDLE);
    assign cmd_done  = (state == S_REL);
    assign cmd_rdata = rdata_q;

    hb8_pins #(.AW(AW), .DW(DW)) u_pins (
        .state(state), .wr_q(wr_q), .sep_q(sep_q), .addr_q(addr_q), .wdata_q(wdata_q),
        .tick(tick), .rd_high(cfg_rd_high), .wr_high(cfg_wr_high), .ale_high(cfg_ale_high),
        .clk_gate(cfg_clk_gate), .clk_gate_idle(cfg_clk_gate_idle),
        .bus_clk(bus_clk), .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_addr(bus_addr)
    );

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && tick && stall) |=> (state == S_DATA && $stable(cnt)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (bus_rd != cfg_rd_high) && (bus_wr != cfg_wr_high));

    p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && !wr_q) |-> !bus_ad_oe);

    p_clk_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk_gate |-> !bus_clk);

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP && !tick) |=> (state == S_GAP));
endmodule

// File: tb/hb8_seq_tb.sv
module hb8_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic cmd_start = 1'b0, cmd_write = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic cmd_idle, cmd_done;
    logic [7:0] cmd_rdata;
    logic cfg_sep_bus = 0, cfg_rd_trim = 0, cfg_wr_trim = 0;
    logic [1:0] cfg_rd_ws = 0, cfg_wr_ws = 0, cfg_rdy_dly = 0, cfg_gap = 2'd2;
    logic cfg_rd_high = 0, cfg_wr_high = 0, cfg_ale_high = 1;
    logic cfg_rdy_en = 0, cfg_rdy_inv = 0, cfg_clk_gate = 0, cfg_clk_gate_idle = 0;
    logic bus_clk, bus_ale, bus_rd, bus_wr, bus_ad_oe;
    logic [7:0] bus_ad_out, bus_ad_in = '0;
    logic [15:0] bus_addr;
    logic bus_rdy = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb8_seq u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_idle(cmd_idle), .cmd_done(cmd_done),
        .cmd_rdata(cmd_rdata), .cfg_sep_bus(cfg_sep_bus), .cfg_rd_ws(cfg_rd_ws),
        .cfg_wr_ws(cfg_wr_ws), .cfg_rd_trim(cfg_rd_trim), .cfg_wr_trim(cfg_wr_trim),
        .cfg_rd_high(cfg_rd_high), .cfg_wr_high(cfg_wr_high), .cfg_ale_high(cfg_ale_high),
        .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_inv(cfg_rdy_inv), .cfg_rdy_dly(cfg_rdy_dly),
        .cfg_gap(cfg_gap), .cfg_clk_gate(cfg_clk_gate), .cfg_clk_gate_idle(cfg_clk_gate_idle),
        .bus_clk(bus_clk), .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_addr(bus_addr), .bus_rdy(bus_rdy)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int tick_div = 1, tdiv = 0, p_target = -1;
    int rd_ticks, wr_ticks, ale_ticks, gap_ticks, done_cycles;
    int addr_err, wdata_err, oe_err, done_err, clk_err, clk_hi_idle, clk_hi_busy;
    bit in_gap = 0, seen_done = 0;
    logic [15:0] cur_addr = '0;
    logic [7:0]  cur_wdata = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        rd_ticks = 0; wr_ticks = 0; ale_ticks = 0; gap_ticks = 0; done_cycles = 0;
        addr_err = 0; wdata_err = 0; oe_err = 0; done_err = 0; seen_done = 0;
    endtask

    // tick source, bus-side model and measurement
    initial begin
        clear_counts();
        clk_err = 0; clk_hi_idle = 0; clk_hi_busy = 0;
        forever begin
            bit rd_act, wr_act, ale_act, stall_now;
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                $finish;
            end
            tick = rst_n && (tdiv >= tick_div - 1);
            tdiv = tick ? 0 : tdiv + 1;
            #1;
            rd_act  = (bus_rd == cfg_rd_high);
            wr_act  = (bus_wr == cfg_wr_high);
            ale_act = (bus_ale == cfg_ale_high);
            stall_now = (rd_act || wr_act) && tick && ((rd_ticks + wr_ticks) == p_target);
            bus_rdy = stall_now ? cfg_rdy_inv : ~cfg_rdy_inv;
            bus_ad_in = cur_addr[7:0] ^ 8'h5A;
            if (rst_n) begin
                if (tick && rd_act) rd_ticks++;
                if (tick && wr_act) wr_ticks++;
                if (tick && ale_act) ale_ticks++;
                if (ale_act && (bus_ad_out != cur_addr[7:0] || !bus_ad_oe)) addr_err++;
                if ((rd_act || wr_act) && cfg_sep_bus && bus_addr != cur_addr) addr_err++;
                if (wr_act && (bus_ad_out != cur_wdata || !bus_ad_oe)) wdata_err++;
                if (rd_act && bus_ad_oe) oe_err++;
                if (cmd_done) begin
                    done_cycles++;
                    if (rd_act || wr_act) done_err++;
                    in_gap = 1; seen_done = 1;
                end else if (in_gap) begin
                    if (cmd_idle) in_gap = 0;
                    else if (tick) gap_ticks++;
                end
                if (bus_clk != (tick && !cfg_clk_gate && (!cfg_clk_gate_idle || !cmd_idle))) clk_err++;
                if (bus_clk && cmd_idle) clk_hi_idle++;
                if (bus_clk && !cmd_idle) clk_hi_busy++;
            end
        end
    end

    task automatic run_tx(input bit wr, input logic [15:0] a, input logic [7:0] d);
        repeat (16) @(negedge clk);
        // R5: idle levels are the inverse of each polarity bit
        chk(bus_rd == ~cfg_rd_high && bus_wr == ~cfg_wr_high && bus_ale == ~cfg_ale_high,
            "R5 idle levels", {bus_rd, bus_wr, bus_ale}, {~cfg_rd_high, ~cfg_wr_high, ~cfg_ale_high});
        clear_counts();
        cur_addr = a; cur_wdata = d;
        cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (!(seen_done && cmd_idle)) @(negedge clk);
    endtask

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cmd_idle == 1'b1 && cmd_done == 1'b0, "R1 idle/done in reset", {cmd_idle, cmd_done}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_idle && !cmd_done && bus_rd == 1'b1 && bus_wr == 1'b1 && bus_ale == 1'b0,
            "R1 after reset", {cmd_idle, cmd_done, bus_rd, bus_wr, bus_ale}, 5'b10110);

        // Sweep: tick rate, bus arrangement, direction, wait code, trim
        idx = 0;
        for (int dv = 1; dv <= 3; dv += 2) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int ws = 0; ws < 4; ws++) begin
                        for (int tr = 0; tr < 2; tr++) begin
                            int exp_w, exp_gap;
                            logic [15:0] a;
                            logic [7:0] d;
                            tick_div = dv; cfg_sep_bus = sp[0];
                            cfg_rd_ws = ws[1:0]; cfg_wr_ws = ws[1:0];
                            cfg_rd_trim = tr[0]; cfg_wr_trim = tr[0];
                            cfg_rd_high = idx[0]; cfg_wr_high = idx[1]; cfg_ale_high = idx[2];
                            cfg_gap = idx[4:3];
                            a = 16'hA300 + 16'(idx * 37);
                            d = 8'(idx * 11 + 3);
                            run_tx(w[0], a, d);
                            exp_w   = 2 * (ws + 1) - tr;
                            exp_gap = (cfg_gap == 2'd1) ? 1 : 2;
                            if (w) begin
                                chk(wr_ticks == exp_w, "R2 write strobe width", wr_ticks, exp_w);
                                chk(rd_ticks == 0, "R2 read strobe idle on write", rd_ticks, 0);
                                chk(wdata_err == 0, "R4 write data drive", wdata_err, 0);
                            end else begin
                                chk(rd_ticks == exp_w, "R2 read strobe width", rd_ticks, exp_w);
                                chk(wr_ticks == 0, "R2 write strobe idle on read", wr_ticks, 0);
                                chk(oe_err == 0, "R4 bus released on read", oe_err, 0);
                                chk(cmd_rdata == (a[7:0] ^ 8'h5A), "R4 read capture",
                                    cmd_rdata, a[7:0] ^ 8'h5A);
                            end
                            chk(ale_ticks == (sp ? 0 : 1), "R3 latch ticks", ale_ticks, sp ? 0 : 1);
                            chk(addr_err == 0, "R3 address presentation", addr_err, 0);
                            chk(done_cycles == 1, "R7 done width", done_cycles, 1);
                            chk(done_err == 0, "R7 strobes quiet at done", done_err, 0);
                            chk(gap_ticks == exp_gap, "R8 gap ticks", gap_ticks, exp_gap);
                            idx++;
                        end
                    end
                end
            end
        end

        // R6: stall pulse placed p data ticks in, latency swept
        tick_div = 1; cfg_sep_bus = 1; cfg_wr_ws = 2'd3; cfg_wr_trim = 0;
        cfg_rd_high = 0; cfg_wr_high = 0; cfg_ale_high = 1; cfg_gap = 2'd1;
        for (int en = 0; en < 2; en++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int dl = 0; dl < 4; dl++) begin
                    for (int p = 5; p <= 6; p++) begin
                        int deff, exp_w;
                        cfg_rdy_en = en[0]; cfg_rdy_inv = inv[0]; cfg_rdy_dly = dl[1:0];
                        p_target = p;
                        run_tx(1'b1, 16'h1234, 8'hC3);
                        p_target = -1;
                        deff  = (dl == 0) ? 1 : dl;
                        exp_w = 8 + ((en && (p + deff <= 7)) ? 1 : 0);
                        chk(wr_ticks == exp_w, "R6 stall lengthens strobe", wr_ticks, exp_w);
                    end
                end
            end
        end
        cfg_rdy_en = 0; cfg_rdy_inv = 0;

        // R9: start pulse during the gap is ignored
        tick_div = 3; cfg_gap = 2'd2; cfg_sep_bus = 0;
        run_tx(1'b0, 16'h0042, 8'h00);
        tick_div = 3;
        begin
            repeat (16) @(negedge clk);
            clear_counts();
            cmd_write = 1'b0; cmd_addr = 16'h0077; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            while (!seen_done) @(negedge clk);
            while (!(in_gap && !cmd_idle && !cmd_done)) @(negedge clk);
            clear_counts();
            cmd_write = 1'b1; cmd_addr = 16'h0099; cmd_start = 1'b1;
            @(negedge clk);
            cmd_start = 1'b0;
            repeat (40) @(negedge clk);
            chk(rd_ticks + wr_ticks + ale_ticks == 0, "R9 no strobe from busy start",
                rd_ticks + wr_ticks + ale_ticks, 0);
            chk(done_cycles == 0, "R9 no done from busy start", done_cycles, 0);
            chk(cmd_idle == 1'b1, "R9 back to idle", cmd_idle, 1);
        end

        // R10: bus clock gating variants
        tick_div = 1;
        for (int gm = 0; gm < 3; gm++) begin
            cfg_clk_gate = (gm == 2); cfg_clk_gate_idle = (gm == 1);
            repeat (4) @(negedge clk);
            clk_err = 0; clk_hi_idle = 0; clk_hi_busy = 0;
            run_tx(1'b1, 16'h0101, 8'h5E);
            repeat (4) @(negedge clk);
            chk(clk_err == 0, "R10 bus clock per cycle", clk_err, 0);
            if (gm == 0) chk(clk_hi_idle > 0 && clk_hi_busy > 0, "R10 free running", clk_hi_idle, 1);
            if (gm == 1) chk(clk_hi_idle == 0 && clk_hi_busy > 0, "R10 idle gated", clk_hi_idle, 0);
            if (gm == 2) chk(clk_hi_idle + clk_hi_busy == 0, "R10 fully gated",
                             clk_hi_idle + clk_hi_busy, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule